// File: doc/BRIEF.md
# Bus-Attached Device Control Responder

This block sits on a peripheral's side of a shared parallel I/O bus. It watches a 10-bit address field, and answers only when the low 6 bits carry its own device number. The upper 4 bits form a function code. With that code the master issues five kinds of command to the device. A control pulse sets or clears mode flip-flops. A sense command asks whether a selected condition is true. An input command moves a word from the device into the master. An output command moves a word from the master into the device. A mask strobe loads the device's interrupt enable.

Readiness is shared across all commands by a single ready flag. The device side sets this flag: it delivers a new word, or it finishes draining the output buffer. The master side clears it with an addressed reset-ready pulse or an addressed output strobe. When the device is not addressed, the reply line and the read data stay at zero, so many responders can be ORed onto one bus. The interrupt request comes straight from flip-flops, so it can be ORed with other devices onto a common line.

The device side uses two valid/ready streams, and both follow back-pressure rules:
- Input stream: a word is taken on a cycle where `dev_in_valid` and `dev_in_ready` are both high. The device must hold its word until then.
- Output stream: `dev_out_valid` stays high, with `dev_out_data` unchanged, until the device raises `dev_out_ready`. The only exception is a fresh output strobe, which replaces the word.

Top module: `devctl_responder`

## Requirements
- R1: The device is addressed when `bus_addr[5:0]` equals parameter `DEV_ID`. The function code is `bus_addr[9:6]`. Addressed-only events are `ctl_pulse`, `rr_pulse` and `ot_strobe`, and each of them has no effect when the address does not match.
- R2: When the address does not match, `bus_reply` and `bus_rdata` are both zero, for any `bus_op`.
- R3: An addressed `ctl_pulse` with function code f < 8 writes bit f[0] into mode flip-flop f[2:1] (`mode_o[f[2:1]]`). A code of 8 or more changes nothing. A control pulse never raises `bus_reply`.
- R4: With `bus_op`=01 (sense) and a matching address, `bus_reply` is true exactly while the selected condition holds: f=0 ready, f=1 not ready, f=2 `mode_o[0]`, f=3 mask. Any other code gives no reply.
- R5: With `bus_op`=10 (input) and a matching address, `bus_reply` equals the ready flag and `bus_rdata` shows the input holding register. An addressed `rr_pulse` clears ready at the next edge.
- R6: With `bus_op`=11 (output) and a matching address, `bus_reply` equals the ready flag. An addressed `ot_strobe` loads `bus_wdata` into the output buffer, clears ready, and raises `dev_out_valid` with that word on the next cycle.
- R7: A `mk_strobe` loads `bus_wdata[MASK_BIT]` into the mask flip-flop whatever the address; the other data bits have no effect.
- R8: `irq_req` is high exactly when ready and mask are both set.
- R9: `dev_in_ready` is high when ready is clear and no output word is pending. An accepted input word loads the holding register and sets ready.
- R10: A pending output word holds `dev_out_valid` and stable `dev_out_data` until `dev_out_ready`. That handshake clears the pending state and sets ready, unless an addressed `ot_strobe` arrives in the same cycle; the new word then stays pending and ready stays clear.
- R11: When a device-side set of ready meets a master-side clear (`rr_pulse`) in the same cycle, ready ends set.
- R12: A synchronous `rst` clears ready, mask, all mode flip-flops, the pending flag and both data registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 10 | Function code [9:6], device number [5:0] |
| bus_op | input | 2 | Command in progress: 00 none, 01 sense, 10 input, 11 output |
| ctl_pulse | input | 1 | Control command pulse |
| rr_pulse | input | 1 | Reset-ready pulse |
| ot_strobe | input | 1 | Output data strobe |
| mk_strobe | input | 1 | Mask load strobe |
| bus_wdata | input | 16 | Output data bus from master |
| bus_reply | output | 1 | Reply line, zero when not addressed |
| bus_rdata | output | 16 | Input data bus to master, zero when not driving |
| irq_req | output | 1 | Interrupt request |
| dev_in_valid | input | 1 | Device offers an input word |
| dev_in_data | input | 16 | Device input word |
| dev_in_ready | output | 1 | Holding register free |
| dev_out_valid | output | 1 | Output word pending for device |
| dev_out_data | output | 16 | Output word |
| dev_out_ready | input | 1 | Device takes the output word |
| mode_o | output | 4 | Mode flip-flops |

## Verification
Ready can be set by the device and cleared by the master in the same cycle. The bench provokes this in two ways. First, it raises `dev_out_ready` on a pending word in the very cycle an addressed `rr_pulse` arrives, and ready must end set. Second, it completes the output handshake in the same cycle as a new addressed `ot_strobe`, and the new word must stay pending with ready clear. A behavioural model computes ready, pending, the buffer and every output on each clock, and the bench compares them against the design at the falling edge.

// File: rtl/devctl_pkg.sv
package devctl_pkg;
  localparam int FUNC_W = 4;
  localparam int DEVNUM_W = 6;
  localparam int ADDR_W = FUNC_W + DEVNUM_W;
  localparam int MODE_N = 4;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_SENSE = 2'b01,
    OP_INPUT = 2'b10,
    OP_OUTPUT = 2'b11
  } bus_op_e;

  typedef logic [FUNC_W-1:0] func_t;
endpackage

// File: rtl/devctl_decode.sv
module devctl_decode
  import devctl_pkg::*;
#(
  parameter logic [DEVNUM_W-1:0] DEV_ID = 6'd13
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        op,
  input  logic              ctl_pulse,
  input  logic              rr_pulse,
  input  logic              ot_strobe,
  output logic              hit,
  output func_t             func,
  output logic              ctl_hit,
  output logic              rr_hit,
  output logic              ot_hit,
  output logic              sense_sel,
  output logic              xfer_in_sel,
  output logic              xfer_out_sel
);
  bus_op_e op_e;

  always_comb begin
    op_e         = bus_op_e'(op);
    hit          = (addr[DEVNUM_W-1:0] == DEV_ID);
    func         = addr[ADDR_W-1:DEVNUM_W];
    ctl_hit      = hit && ctl_pulse;
    rr_hit       = hit && rr_pulse;
    ot_hit       = hit && ot_strobe;
    sense_sel    = hit && (op_e == OP_SENSE);
    xfer_in_sel  = hit && (op_e == OP_INPUT);
    xfer_out_sel = hit && (op_e == OP_OUTPUT);
  end
endmodule

// File: rtl/devctl_flags.sv
module devctl_flags
  import devctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              set_ev,
  input  logic              clr_ev,
  input  logic              ctl_hit,
  input  func_t             func,
  input  logic              mk_strobe,
  input  logic              mask_bit,
  output logic              rdy_q,
  output logic              mask_q,
  output logic [MODE_N-1:0] modes_q
);
  localparam int IDX_W = $clog2(MODE_N);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q <= 1'b0;
    end else if (set_ev) begin
      rdy_q <= 1'b1;
    end else if (clr_ev) begin
      rdy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= 1'b0;
    end else if (mk_strobe) begin
      mask_q <= mask_bit;
    end
  end

  logic mode_wr;
  logic [IDX_W-1:0] mode_idx;
  assign mode_wr  = ctl_hit && !func[FUNC_W-1];
  assign mode_idx = func[IDX_W:1];

  for (genvar g = 0; g < MODE_N; g++) begin : g_mode
    always_ff @(posedge clk) begin
      if (rst) begin
        modes_q[g] <= 1'b0;
      end else if (mode_wr && (mode_idx == IDX_W'(g))) begin
        modes_q[g] <= func[0];
      end
    end
  end

  p_clear_wins_without_set_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_ev && !set_ev) |=> !rdy_q);
  p_set_beats_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (set_ev && clr_ev) |=> rdy_q);
  p_mask_load_r7: assert property (@(posedge clk) disable iff (rst)
    mk_strobe |=> (mask_q == $past(mask_bit)));
  p_high_codes_inert_r3: assert property (@(posedge clk) disable iff (rst)
    (ctl_hit && func[FUNC_W-1]) |=> $stable(modes_q));
  p_reset_clears_r12: assert property (@(posedge clk)
    rst |=> (!rdy_q && !mask_q && modes_q == '0));
endmodule

// File: rtl/devctl_datapath.sv
module devctl_datapath #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdy_q,
  input  logic              ot_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic              dev_in_valid,
  input  logic [DATA_W-1:0] dev_in_data,
  output logic              dev_in_ready,
  output logic              dev_out_valid,
  output logic [DATA_W-1:0] dev_out_data,
  input  logic              dev_out_ready,
  output logic [DATA_W-1:0] hold_q,
  output logic              in_take,
  output logic              out_done
);
  logic              pend_q;
  logic [DATA_W-1:0] obuf_q;
  logic              out_hs;

  assign dev_in_ready  = !rdy_q && !pend_q;
  assign in_take       = dev_in_valid && dev_in_ready;
  assign out_hs        = pend_q && dev_out_ready;
  assign out_done      = out_hs && !ot_hit;
  assign dev_out_valid = pend_q;
  assign dev_out_data  = obuf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
    end else if (in_take) begin
      hold_q <= dev_in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      obuf_q <= '0;
    end else if (ot_hit) begin
      pend_q <= 1'b1;
      obuf_q <= wdata;
    end else if (out_hs) begin
      pend_q <= 1'b0;
    end
  end

  p_strobe_loads_buffer_r6: assert property (@(posedge clk) disable iff (rst)
    ot_hit |=> (dev_out_valid && dev_out_data == $past(wdata)));
  p_out_hold_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (dev_out_valid && !dev_out_ready && !ot_hit) |=> (dev_out_valid && $stable(dev_out_data)));
  p_in_take_loads_r9: assert property (@(posedge clk) disable iff (rst)
    in_take |=> (hold_q == $past(dev_in_data)));
endmodule

// File: rtl/devctl_responder.sv
module devctl_responder
  import devctl_pkg::*;
#(
  parameter logic [DEVNUM_W-1:0] DEV_ID = 6'd13,
  parameter int DATA_W = 16,
  parameter int MASK_BIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [9:0]        bus_addr,
  input  logic [1:0]        bus_op,
  input  logic              ctl_pulse,
  input  logic              rr_pulse,
  input  logic              ot_strobe,
  input  logic              mk_strobe,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_reply,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_req,
  input  logic              dev_in_valid,
  input  logic [DATA_W-1:0] dev_in_data,
  output logic              dev_in_ready,
  output logic              dev_out_valid,
  output logic [DATA_W-1:0] dev_out_data,
  input  logic              dev_out_ready,
  output logic [3:0]        mode_o
);
  logic hit, ctl_hit, rr_hit, ot_hit, sense_sel, in_sel, out_sel;
  func_t func;
  logic rdy_q, mask_q, in_take, out_done, cond;
  logic [MODE_N-1:0] modes_q;
  logic [DATA_W-1:0] hold_q;

  devctl_decode #(.DEV_ID(DEV_ID)) u_dec (
    .addr(bus_addr), .op(bus_op), .ctl_pulse(ctl_pulse), .rr_pulse(rr_pulse),
    .ot_strobe(ot_strobe), .hit(hit), .func(func), .ctl_hit(ctl_hit),
    .rr_hit(rr_hit), .ot_hit(ot_hit), .sense_sel(sense_sel),
    .xfer_in_sel(in_sel), .xfer_out_sel(out_sel)
  );

  devctl_flags u_flags (
    .clk(clk), .rst(rst), .set_ev(in_take || out_done), .clr_ev(rr_hit || ot_hit),
    .ctl_hit(ctl_hit), .func(func), .mk_strobe(mk_strobe),
    .mask_bit(bus_wdata[MASK_BIT]), .rdy_q(rdy_q), .mask_q(mask_q), .modes_q(modes_q)
  );

  devctl_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .rdy_q(rdy_q), .ot_hit(ot_hit), .wdata(bus_wdata),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
    .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
    .dev_out_ready(dev_out_ready), .hold_q(hold_q), .in_take(in_take), .out_done(out_done)
  );

  always_comb begin
    case (func)
      4'd0:    cond = rdy_q;
      4'd1:    cond = !rdy_q;
      4'd2:    cond = modes_q[0];
      4'd3:    cond = mask_q;
      default: cond = 1'b0;
    endcase
  end

  assign bus_reply = (sense_sel && cond) || ((in_sel || out_sel) && rdy_q);
  assign bus_rdata = in_sel ? hold_q : '0;
  assign irq_req   = rdy_q && mask_q;
  assign mode_o    = modes_q;

  p_quiet_unaddressed_r2: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (!bus_reply && bus_rdata == '0));
  p_irq_follows_flags_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> (mask_q && rdy_q));
  p_in_sets_ready_r9: assert property (@(posedge clk) disable iff (rst)
    (dev_in_valid && dev_in_ready) |=> (irq_req == mask_q));
  p_ctl_no_reply_r3: assert property (@(posedge clk) disable iff (rst)
    (ctl_pulse && bus_op == 2'b00) |-> !bus_reply);
endmodule

// File: tb/devctl_responder_tb.sv
module devctl_responder_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] DEV = 6'd13;
  localparam int MB = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [9:0] bus_addr = '0;
  logic [1:0] bus_op = '0;
  logic ctl_pulse = 0, rr_pulse = 0, ot_strobe = 0, mk_strobe = 0;
  logic [15:0] bus_wdata = '0;
  logic bus_reply, irq_req, dev_in_ready, dev_out_valid;
  logic [15:0] bus_rdata, dev_out_data;
  logic dev_in_valid = 0, dev_out_ready = 0;
  logic [15:0] dev_in_data = '0;
  logic [3:0] mode_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  devctl_responder #(.DEV_ID(DEV), .DATA_W(16), .MASK_BIT(MB)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_op(bus_op), .ctl_pulse(ctl_pulse),
    .rr_pulse(rr_pulse), .ot_strobe(ot_strobe), .mk_strobe(mk_strobe),
    .bus_wdata(bus_wdata), .bus_reply(bus_reply), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
    .dev_in_ready(dev_in_ready), .dev_out_valid(dev_out_valid),
    .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready), .mode_o(mode_o)
  );

  int n_chk = 0, n_fail = 0;
  bit chk_on = 0;

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference state
  bit m_rdy, m_mask, m_pend;
  bit [3:0] m_modes;
  logic [15:0] m_hold, m_buf;

  function automatic bit e_match(); return bus_addr[5:0] == DEV; endfunction
  function automatic int e_func(); return int'(bus_addr[9:6]); endfunction

  function automatic bit e_reply();
    if (!e_match()) return 0;
    if (bus_op == 2'b01) begin
      case (e_func())
        0: return m_rdy;
        1: return !m_rdy;
        2: return m_modes[0];
        3: return m_mask;
        default: return 0;
      endcase
    end
    if (bus_op == 2'b10 || bus_op == 2'b11) return m_rdy;
    return 0;
  endfunction

  always @(posedge clk) begin
    bit in_acc, ot_hit, out_hs, rr_hit, setv, clrv;
    if (rst) begin
      m_rdy = 0; m_mask = 0; m_pend = 0; m_modes = 0; m_hold = 0; m_buf = 0;
    end else begin
      in_acc = dev_in_valid && !m_rdy && !m_pend;
      ot_hit = ot_strobe && e_match();
      rr_hit = rr_pulse && e_match();
      out_hs = m_pend && dev_out_ready;
      setv = in_acc || (out_hs && !ot_hit);
      clrv = rr_hit || ot_hit;
      if (setv) m_rdy = 1; else if (clrv) m_rdy = 0;
      if (ot_hit) begin m_pend = 1; m_buf = bus_wdata; end
      else if (out_hs) m_pend = 0;
      if (in_acc) m_hold = dev_in_data;
      if (mk_strobe) m_mask = bus_wdata[MB];
      if (ctl_pulse && e_match() && e_func() < 8) m_modes[e_func() / 2] = e_func() % 2 == 1;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      cmp("R4 reply", 32'(bus_reply), 32'(e_reply()));
      cmp("R5 rdata", 32'(bus_rdata), (e_match() && bus_op == 2'b10) ? 32'(m_hold) : 32'd0);
      cmp("R8 irq", 32'(irq_req), 32'(m_rdy && m_mask));
      cmp("R3 modes", 32'(mode_o), 32'(m_modes));
      cmp("R9 in_ready", 32'(dev_in_ready), 32'(!m_rdy && !m_pend));
      cmp("R10 out_valid", 32'(dev_out_valid), 32'(m_pend));
      cmp("R6 out_data", 32'(dev_out_data), 32'(m_buf));
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic idle();
    bus_op = 0; ctl_pulse = 0; rr_pulse = 0; ot_strobe = 0; mk_strobe = 0;
    dev_in_valid = 0; dev_out_ready = 0;
  endtask

  function automatic logic [9:0] ad(int f, logic [5:0] d);
    return {4'(f), d};
  endfunction

  initial begin
    cyc(3);
    rst = 0; chk_on = 1;
    #1;
    cmp("R12 reset irq", 32'(irq_req), 0);
    cmp("R12 reset modes", 32'(mode_o), 0);
    cmp("R12 reset in_ready", 32'(dev_in_ready), 1);
    cyc();
    // R9: device pushes a word
    dev_in_valid = 1; dev_in_data = 16'hA5A5; cyc(); idle();
    #1; cmp("R9 ready after push (busy sense)", 32'(dev_in_ready), 0);
    cyc();
    // R4 / R1 / R2 sense
    bus_addr = ad(0, DEV); bus_op = 2'b01; #1;
    cmp("R4 sense ready", 32'(bus_reply), 1); cyc();
    bus_addr = ad(0, DEV ^ 6'd1); #1;
    cmp("R1 R2 other address silent", 32'(bus_reply), 0); cyc();
    bus_addr = ad(1, DEV); cyc();
    bus_addr = ad(7, DEV); cyc();
    // R7 / R8 mask
    idle(); mk_strobe = 1; bus_wdata = 16'h0020; bus_addr = ad(0, 6'd2); cyc(); idle();
    #1; cmp("R8 irq raised", 32'(irq_req), 1); cyc();
    mk_strobe = 1; bus_wdata = 16'hFFDF; cyc(); idle();
    #1; cmp("R7 other bits ignored", 32'(irq_req), 0); cyc();
    mk_strobe = 1; bus_wdata = 16'h0020; cyc(); idle();
    bus_addr = ad(3, DEV); bus_op = 2'b01; cyc();
    // R5 input with rr
    bus_addr = ad(0, DEV); bus_op = 2'b10; #1;
    cmp("R5 rdata", 32'(bus_rdata), 32'h0000A5A5);
    bus_op = 2'b10; bus_addr = ad(0, DEV ^ 6'd4); rr_pulse = 1; cyc();
    idle(); #1; cmp("R1 unaddressed rr ignored", 32'(irq_req), 1);
    bus_addr = ad(0, DEV); bus_op = 2'b10; rr_pulse = 1; cyc(); idle();
    #1; cmp("R5 rr clears ready", 32'(dev_in_ready), 1); cyc();
    // R3 control pulses
    ctl_pulse = 1; bus_addr = ad(1, DEV); cyc();
    bus_addr = ad(5, DEV); cyc();
    bus_addr = ad(9, DEV); cyc();
    bus_addr = ad(3, DEV ^ 6'd8); cyc();
    bus_addr = ad(7, DEV); cyc();
    bus_addr = ad(6, DEV); idle(); ctl_pulse = 1; cyc(); idle();
    #1; cmp("R3 modes pattern", 32'(mode_o), 32'h5);
    bus_addr = ad(2, DEV); bus_op = 2'b01; cyc();
    // R6 output
    idle(); dev_in_valid = 1; dev_in_data = 16'h0F0F; cyc(); idle();
    bus_addr = ad(0, DEV); bus_op = 2'b11; #1;
    cmp("R6 reply ready", 32'(bus_reply), 1);
    ot_strobe = 1; bus_wdata = 16'h1234; cyc(); idle();
    #1; cmp("R6 out word", 32'(dev_out_data), 32'h1234);
    cyc(2);
    // R11: handshake meets reset-ready
    dev_out_ready = 1; rr_pulse = 1; bus_addr = ad(0, DEV); cyc(); idle();
    #1; cmp("R11 set beats clear", 32'(irq_req), 1); cyc();
    // R10: handshake meets new strobe
    bus_addr = ad(0, DEV); ot_strobe = 1; bus_wdata = 16'hBEEF; cyc(); idle();
    cyc();
    ot_strobe = 1; bus_wdata = 16'hC0DE; dev_out_ready = 1; cyc(); idle();
    #1; cmp("R10 new word pending", 32'(dev_out_valid), 1);
    cmp("R10 ready stays clear", 32'(irq_req), 0);
    dev_out_ready = 1; cyc(); idle();
    // R12 reset mid-run
    dev_in_valid = 1; dev_in_data = 16'h7777; cyc(); idle();
    rst = 1; cyc(); rst = 0; #1;
    cmp("R12 reset clears", 32'({irq_req, mode_o, dev_out_valid}), 0);
    cyc(3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired (all requirements)");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule